// File: doc/BRIEF.md
# Hysteretic PWM Mode Selector

This block chooses which of three PWM configuration words is handed to a PWM generator. The choice follows the loop filter's duty output. There are three operating regions: base, mid and high. Each of the two boundaries between neighbouring regions has its own pair of thresholds, one for rising and one for falling. The gap between the two thresholds of a pair gives hysteresis, so a duty value that hovers near a boundary does not make the configuration chatter.

Each duty-valid strobe starts an evaluation. The evaluation moves a pending region by at most one step. The pending region becomes the active region only on a PWM period boundary, so the configuration never changes partway through a period. The selected word is read live from the chosen configuration input, so an edit to that word takes effect at once.

When automatic switching is disabled, or while reset is held, the block is pinned to the base configuration.

Top module: `pwm_cfg_selector`

## Requirements
- R1: While reset is held and on the first cycle after it, `region` is 0 and `cfg_out` equals `cfg_base`.
- R2: `region` encodes the active region as follows: 0 is base, 1 is mid and 2 is high. The value 3 never appears. `cfg_out` is combinationally equal to `cfg_base`, `cfg_mid` or `cfg_high` for the active region, so it follows edits to that word in the same cycle.
- R3: An evaluation with the pending region at base moves the pending region to mid only when `duty` is strictly greater than `th_lo_rise`.
- R4: An evaluation with the pending region at mid moves the pending region to base only when `duty` is strictly less than `th_lo_fall`.
- R5: An evaluation with the pending region at mid moves it to high when `duty` is strictly greater than `th_hi_rise`. An evaluation with the pending region at high moves it to mid when `duty` is strictly less than `th_hi_fall`.
- R6: A duty value exactly equal to any threshold causes no region change.
- R7: An evaluation happens only on a cycle with `duty_vld` high. Changes of `duty` on other cycles have no effect.
- R8: An evaluation moves the pending region by at most one step. A very large duty seen at base reaches mid, not high.
- R9: `region` and `cfg_out` change only on the clock edge where `period_end` is high. At that edge they take the pending region held before that edge. If `duty_vld` and `period_end` are high in the same cycle, the new evaluation waits for the following boundary.
- R10: While `auto_en` is low, both the pending and active regions are forced to base from the next edge. Strobes are ignored, so re-enabling starts from base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_en | input | 1 | Enables automatic region switching |
| duty | input | DUTY_W | Filter duty value |
| duty_vld | input | 1 | Strobe: duty is valid, evaluate this cycle |
| period_end | input | 1 | PWM period boundary, commit pending region |
| cfg_base | input | CFG_W | Configuration word for the base region |
| cfg_mid | input | CFG_W | Configuration word for the mid region |
| cfg_high | input | CFG_W | Configuration word for the high region |
| th_lo_rise | input | DUTY_W | Base-to-mid rising threshold |
| th_lo_fall | input | DUTY_W | Mid-to-base falling threshold |
| th_hi_rise | input | DUTY_W | Mid-to-high rising threshold |
| th_hi_fall | input | DUTY_W | High-to-mid falling threshold |
| cfg_out | output | CFG_W | Selected configuration word |
| region | output | 2 | Active region: 0 base, 1 mid, 2 high |

## Verification
A strobe that moves the pending region shows on the ports no earlier than the edge of the next `period_end`. The region is therefore due one edge after the boundary cycle that follows the strobe. `cfg_out` also changes with no delay when the selected word is edited, and a low `auto_en` forces base one edge later.

The bench drives inputs on the falling edge. A behavioural model updates on every rising edge. Both outputs are compared with the model on each falling edge. Directed checks at fixed points confirm the values that each requirement predicts for those cycles.

// File: rtl/pwm_sel_pkg.sv
package pwm_sel_pkg;

    // Active/pending region encoding (R2)
    typedef enum logic [1:0] {
        REG_BASE = 2'd0,
        REG_MID  = 2'd1,
        REG_HIGH = 2'd2
    } region_e;

    localparam int NUM_REGIONS = 3;

    // Strict threshold comparison results for one evaluation
    typedef struct packed {
        logic over_lo_rise;
        logic under_lo_fall;
        logic over_hi_rise;
        logic under_hi_fall;
    } cmp_t;

    // One-step hysteretic move; rising move is considered first at mid
    function automatic region_e step_region(region_e cur, cmp_t c);
        region_e nxt;
        nxt = cur;
        unique case (cur)
            REG_BASE: if (c.over_lo_rise)  nxt = REG_MID;
            REG_MID: begin
                if (c.over_hi_rise)        nxt = REG_HIGH;
                else if (c.under_lo_fall)  nxt = REG_BASE;
            end
            REG_HIGH: if (c.under_hi_fall) nxt = REG_MID;
            default:                       nxt = REG_BASE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/pwm_sel_cmp.sv
module pwm_sel_cmp
    import pwm_sel_pkg::*;
#(
    parameter int DUTY_W = 16
) (
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] th_lo_rise,
    input  logic [DUTY_W-1:0] th_lo_fall,
    input  logic [DUTY_W-1:0] th_hi_rise,
    input  logic [DUTY_W-1:0] th_hi_fall,
    output cmp_t              cmp
);
    // All comparisons strict: equality never crosses a boundary (R6)
    always_comb begin
        cmp.over_lo_rise  = duty > th_lo_rise;
        cmp.under_lo_fall = duty < th_lo_fall;
        cmp.over_hi_rise  = duty > th_hi_rise;
        cmp.under_hi_fall = duty < th_hi_fall;
    end
endmodule

// File: rtl/pwm_sel_eval.sv
module pwm_sel_eval
    import pwm_sel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    auto_en,
    input  logic    duty_vld,
    input  cmp_t    cmp,
    output region_e pend
);
    region_e pend_q;
    region_e pend_d;

    always_comb begin
        pend_d = pend_q;
        if (duty_vld) pend_d = step_region(pend_q, cmp);
    end

    always_ff @(posedge clk) begin
        if (rst || !auto_en) pend_q <= REG_BASE;
        else                 pend_q <= pend_d;
    end

    assign pend = pend_q;

    AST_PEND_NO_JUMP: assert property (@(posedge clk) disable iff (rst)
        ($past(pend_q) == REG_BASE) |-> (pend_q != REG_HIGH)); // R8

    AST_PEND_NO_DROP2: assert property (@(posedge clk) disable iff (rst)
        ($past(pend_q) == REG_HIGH && $past(auto_en)) |-> (pend_q != REG_BASE)); // R8

    AST_PEND_NEEDS_VLD: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !duty_vld) |=> (pend_q == $past(pend_q))); // R7

    AST_BASE_STRICT: assert property (@(posedge clk) disable iff (rst)
        (auto_en && duty_vld && pend_q == REG_BASE && !cmp.over_lo_rise)
        |=> (pend_q == REG_BASE)); // R3
endmodule

// File: rtl/pwm_sel_commit.sv
module pwm_sel_commit
    import pwm_sel_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    auto_en,
    input  logic    period_end,
    input  region_e pend,
    output region_e act
);
    region_e act_q;

    always_ff @(posedge clk) begin
        if (rst || !auto_en)  act_q <= REG_BASE;
        else if (period_end)  act_q <= pend;
    end

    assign act = act_q;

    AST_COMMIT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
        (auto_en && !period_end) |=> (act_q == $past(act_q))); // R9

    AST_COMMIT_TAKES_PEND: assert property (@(posedge clk) disable iff (rst)
        (auto_en && period_end) |=> (act_q == $past(pend))); // R9
endmodule

// File: rtl/pwm_sel_mux.sv
module pwm_sel_mux
    import pwm_sel_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic [NUM_REGIONS-1:0][CFG_W-1:0] words,
    input  region_e                           sel,
    output logic [CFG_W-1:0]                  word_out
);
    localparam int IDX_W = $clog2(NUM_REGIONS);

    logic [NUM_REGIONS-1:0][CFG_W-1:0] gated;

    // One-hot AND-OR selection, one lane per region
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lane
        assign gated[g] = (sel == region_e'(IDX_W'(g))) ? words[g] : '0;
    end

    always_comb begin
        word_out = '0;
        for (int i = 0; i < NUM_REGIONS; i++) word_out = word_out | gated[i];
    end
endmodule

// File: rtl/pwm_cfg_selector.sv
module pwm_cfg_selector
    import pwm_sel_pkg::*;
#(
    parameter int DUTY_W = 16,
    parameter int CFG_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_en,
    input  logic [DUTY_W-1:0] duty,
    input  logic              duty_vld,
    input  logic              period_end,
    input  logic [CFG_W-1:0]  cfg_base,
    input  logic [CFG_W-1:0]  cfg_mid,
    input  logic [CFG_W-1:0]  cfg_high,
    input  logic [DUTY_W-1:0] th_lo_rise,
    input  logic [DUTY_W-1:0] th_lo_fall,
    input  logic [DUTY_W-1:0] th_hi_rise,
    input  logic [DUTY_W-1:0] th_hi_fall,
    output logic [CFG_W-1:0]  cfg_out,
    output logic [1:0]        region
);
    cmp_t    cmp;
    region_e pend;
    region_e act;
    logic [NUM_REGIONS-1:0][CFG_W-1:0] words;

    assign words[REG_BASE] = cfg_base;
    assign words[REG_MID]  = cfg_mid;
    assign words[REG_HIGH] = cfg_high;

    pwm_sel_cmp #(.DUTY_W(DUTY_W)) u_cmp (
        .duty       (duty),
        .th_lo_rise (th_lo_rise),
        .th_lo_fall (th_lo_fall),
        .th_hi_rise (th_hi_rise),
        .th_hi_fall (th_hi_fall),
        .cmp        (cmp)
    );

    pwm_sel_eval u_eval (
        .clk      (clk),
        .rst      (rst),
        .auto_en  (auto_en),
        .duty_vld (duty_vld),
        .cmp      (cmp),
        .pend     (pend)
    );

    pwm_sel_commit u_commit (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (auto_en),
        .period_end (period_end),
        .pend       (pend),
        .act        (act)
    );

    pwm_sel_mux #(.CFG_W(CFG_W)) u_mux (
        .words    (words),
        .sel      (act),
        .word_out (cfg_out)
    );

    assign region = act;

    AST_REGION_LEGAL: assert property (@(posedge clk) disable iff (rst)
        region != 2'd3); // R2

    AST_FORCED_BASE: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> (region == 2'd0 && cfg_out == cfg_base)); // R10

    AST_RESET_BASE: assert property (@(posedge clk)
        rst |=> (region == 2'd0)); // R1

    AST_OUT_TRACKS_MID: assert property (@(posedge clk) disable iff (rst)
        (region == 2'd1) |-> (cfg_out == cfg_mid)); // R2
endmodule

// File: tb/pwm_cfg_selector_tb.sv
module pwm_cfg_selector_tb;
    localparam int DW = 16;
    localparam int CW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          auto_en = 1'b1;
    logic [DW-1:0] duty = '0;
    logic          duty_vld = 1'b0;
    logic          period_end = 1'b0;
    logic [CW-1:0] cfg_base = 32'hB0B0_0001;
    logic [CW-1:0] cfg_mid  = 32'h3131_0002;
    logic [CW-1:0] cfg_high = 32'h4A4A_0003;
    logic [DW-1:0] th_lo_fall = 16'd100;
    logic [DW-1:0] th_lo_rise = 16'd200;
    logic [DW-1:0] th_hi_fall = 16'd400;
    logic [DW-1:0] th_hi_rise = 16'd500;
    logic [CW-1:0] cfg_out;
    logic [1:0]    region;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference: pending and active region as integers
    int m_pend = 0;
    int m_act  = 0;

    always #10 clk = ~clk;

    pwm_cfg_selector #(.DUTY_W(DW), .CFG_W(CW)) u_dut (
        .clk(clk), .rst(rst), .auto_en(auto_en), .duty(duty),
        .duty_vld(duty_vld), .period_end(period_end),
        .cfg_base(cfg_base), .cfg_mid(cfg_mid), .cfg_high(cfg_high),
        .th_lo_rise(th_lo_rise), .th_lo_fall(th_lo_fall),
        .th_hi_rise(th_hi_rise), .th_hi_fall(th_hi_fall),
        .cfg_out(cfg_out), .region(region)
    );

    always @(posedge clk) begin
        int old_pend;
        old_pend = m_pend;
        if (rst || !auto_en) begin
            m_pend = 0;
            m_act  = 0;
        end else begin
            if (period_end) m_act = old_pend;
            if (duty_vld) begin
                if (old_pend == 0 && duty > th_lo_rise)      m_pend = 1;
                else if (old_pend == 1 && duty > th_hi_rise) m_pend = 2;
                else if (old_pend == 1 && duty < th_lo_fall) m_pend = 0;
                else if (old_pend == 2 && duty < th_hi_fall) m_pend = 1;
            end
        end
    end

    function automatic logic [CW-1:0] exp_word(int r);
        if (r == 1) return cfg_mid;
        if (r == 2) return cfg_high;
        return cfg_base;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint actv, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, actv, expv, $time);
        end
    endtask

    task automatic cmp_model();
        chk(region == 2'(m_act), "R9 model region", region, m_act);
        chk(cfg_out == exp_word(m_act), "R2 model word", cfg_out, exp_word(m_act));
    endtask

    // Drive on the falling edge, let one rising edge pass, compare on next falling edge
    task automatic cyc(input bit v, input int d, input bit pe);
        duty_vld = v;
        duty = DW'(d);
        period_end = pe;
        @(posedge clk);
        @(negedge clk);
        duty_vld = 0;
        period_end = 0;
        cmp_model();
    endtask

    task automatic expect_region(input int r, input string tag);
        chk(region == 2'(r), tag, region, r);
        chk(cfg_out == exp_word(r), tag, cfg_out, exp_word(r));
    endtask

    initial begin
        @(negedge clk);
        @(negedge clk);
        expect_region(0, "R1 in reset");
        rst = 0;
        @(posedge clk);
        @(negedge clk);
        expect_region(0, "R1 after reset");

        cyc(1, 200, 0); cyc(0, 0, 1);
        expect_region(0, "R6 equal lo_rise");
        cyc(1, 201, 0);
        expect_region(0, "R9 not before boundary");
        cyc(0, 0, 1);
        expect_region(1, "R3 base to mid");
        cfg_mid = 32'h5555_AAAA;
        #1;
        chk(cfg_out == 32'h5555_AAAA, "R2 live word", cfg_out, 32'h5555_AAAA);
        @(negedge clk);

        cyc(0, 900, 0); cyc(0, 900, 1);
        expect_region(1, "R7 no strobe");
        cyc(1, 500, 0); cyc(0, 0, 1);
        expect_region(1, "R6 equal hi_rise");
        cyc(1, 501, 0); cyc(0, 0, 1);
        expect_region(2, "R5 mid to high");
        cyc(1, 400, 0); cyc(0, 0, 1);
        expect_region(2, "R6 equal hi_fall");
        cyc(1, 399, 0); cyc(0, 0, 1);
        expect_region(1, "R5 high to mid");
        cyc(1, 100, 0); cyc(0, 0, 1);
        expect_region(1, "R6 equal lo_fall");
        cyc(1, 99, 0); cyc(0, 0, 1);
        expect_region(0, "R4 mid to base");

        cyc(1, 60000, 1);
        expect_region(0, "R9 same-cycle strobe waits");
        cyc(0, 0, 1);
        expect_region(1, "R8 one step only");

        cyc(1, 900, 0); cyc(1, 300, 0); cyc(0, 0, 1);
        expect_region(1, "R9 last evaluation wins");

        cyc(1, 900, 0); cyc(0, 0, 1);
        expect_region(2, "R5 high again");
        auto_en = 0;
        cyc(0, 0, 0);
        expect_region(0, "R10 forced base");
        cyc(1, 900, 0); cyc(0, 0, 1);
        expect_region(0, "R10 strobe ignored");
        auto_en = 1;
        cyc(0, 0, 1);
        expect_region(0, "R10 pending cleared");

        for (int i = 0; i < 200; i++) begin
            cyc((i % 3) != 0, (i * 37) % 700, (i % 4) == 3);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule